// File: doc/BRIEF.md
# Latched Reloadable Interval Timer

This block is a down-counting interval timer with a pair of byte-wide reload latches. A processor reaches it through a small byte-wide register interface. The counter is twice the byte width. It is loaded as a whole when its high byte is written: the written byte goes to the high half, and the low half is copied from the low latch. From then on the counter decrements once per clock.

Two modes are available.
- **One-shot:** the timer raises its interrupt flag once per load. The counter then keeps running past zero, so software can read how long ago the timeout happened.
- **Free-running:** every time the counter reaches zero it reloads the full latch value, sets the flag and inverts an output level.

The latches can be rewritten at any time without disturbing a countdown in progress. This lets software set the length of the next period while the current one is still running, so periodic interrupts and the square wave stay free of software response jitter.

A two-bit mode field, written through a strobe, selects free-running operation and hands a shared port pin to the timer. While the timer owns the pin, the port's own data bit has no effect on it. The interrupt request combines the flag with an enable input.

Top module: `latch_interval_timer`

## Requirements
- R1: Reset clears the flag, the one-shot arming and both mode bits, and sets the timer output level high. The latch and counter contents are not reset; both latches read back their earlier values after a reset.
- R2: A write to register index 1 (the counter high byte) has the following effects on the next cycle:
  - the high latch and counter bits [15:8] hold the written byte;
  - counter bits [7:0] hold the low latch;
  - the flag is clear;
  - the countdown starts.
- R3: In every cycle without such a load, and while the counter is not zero, the counter decreases by exactly one.
- R4: Writes to index 0 or 2 load only the low latch, and writes to index 3 load only the high latch. Neither changes the count in progress. A write to index 3 also clears the flag.
- R5: The read data shows the byte selected by the index:
  - index 0: counter low byte;
  - index 1: counter high byte;
  - index 2: low latch;
  - index 3: high latch.
  A read access to index 0 clears the flag; reads at the other indices have no side effect.
- R6: In one-shot mode (mode bit 0 = 0), when an armed counter passes from zero it continues from all ones and the flag sets.
- R7: In one-shot mode, the flag does not set again until a new index-1 write, even when the counter passes zero again.
- R8: In free-running mode (mode bit 0 = 1), each time the counter is zero it reloads the full 16-bit latch value, sets the flag and inverts the output level.
- R9: An index-1 write drives the output level low on the next cycle. In one-shot mode a timeout returns the level high.
- R10: With mode bit 1 = 1 the pin is driven by the timer level and the pin's output enable is 1, whatever the port bit says. With mode bit 1 = 0 the pin follows the port data bit and the output enable follows the port direction bit.
- R11: The interrupt request is high exactly when the flag is set and the interrupt enable input is 1.
- R12: The flag-clear input clears the flag. If a timeout falls in the same cycle, the set wins.
- R13: A pulse on the mode write strobe loads the two mode bits on that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the count rate |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel_i | input | 1 | Register access strobe, one cycle per access |
| bus_wr_i | input | 1 | 1 = write access, 0 = read access |
| bus_addr_i | input | 2 | Register index |
| bus_wdata_i | input | BYTE_W | Write data |
| bus_rdata_o | output | BYTE_W | Read data for the current index |
| aux_wr_i | input | 1 | Mode field write strobe |
| aux_mode_i | input | 2 | Bit 1: timer owns the pin; bit 0: free-running |
| irq_en_i | input | 1 | Interrupt enable |
| flag_clr_i | input | 1 | Direct flag clear |
| port_bit_i | input | 1 | Port data bit for the shared pin |
| port_dir_i | input | 1 | Port direction bit, 1 = output |
| flag_o | output | 1 | Interrupt flag |
| irq_o | output | 1 | Interrupt request |
| pin_o | output | 1 | Shared pin output value |
| pin_oe_o | output | 1 | Shared pin output enable |

## Verification
The bench builds the block with BYTE_W = 8, which gives a 16-bit counter. A full wrap then takes 65536 cycles, so a one-shot countdown can be followed past zero a second time to confirm that no second flag appears. The latch values are kept small (3 and 0x0140) so that several free-running periods, reload and level toggling fit into a few dozen cycles. A flag clear can also be placed exactly on a timeout edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        REG_CNT_LO = 2'd0,
        REG_CNT_HI = 2'd1,
        REG_LAT_LO = 2'd2,
        REG_LAT_HI = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic start;
        logic wr_lat_lo;
        logic wr_lat_hi;
        logic rd_cnt_lo;
        logic clr_by_latch;
    } bus_cmd_t;

    typedef struct packed {
        logic flag;
        logic armed;
        logic lvl;
        logic out_en;
        logic free_run;
    } tmr_ctl_t;

    localparam tmr_ctl_t CTL_RESET = '{
        flag:     1'b0,
        armed:    1'b0,
        lvl:      1'b1,
        out_en:   1'b0,
        free_run: 1'b0
    };

endpackage

// File: rtl/tmr_regif.sv
module tmr_regif
    import tmr_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                  sel,
    input  logic                  wr,
    input  logic [1:0]            addr,
    input  logic [2*BYTE_W-1:0]   cnt,
    input  logic [BYTE_W-1:0]     lat_lo,
    input  logic [BYTE_W-1:0]     lat_hi,
    output bus_cmd_t              cmd,
    output logic [BYTE_W-1:0]     rdata
);
    localparam int CNT_W = 2 * BYTE_W;

    reg_sel_e rsel;
    logic     wr_acc;
    logic     rd_acc;

    always_comb begin
        rsel   = reg_sel_e'(addr);
        wr_acc = sel && wr;
        rd_acc = sel && !wr;

        cmd              = '0;
        cmd.start        = wr_acc && (rsel == REG_CNT_HI);
        cmd.wr_lat_lo    = wr_acc && ((rsel == REG_CNT_LO) || (rsel == REG_LAT_LO));
        cmd.wr_lat_hi    = wr_acc && ((rsel == REG_CNT_HI) || (rsel == REG_LAT_HI));
        cmd.rd_cnt_lo    = rd_acc && (rsel == REG_CNT_LO);
        cmd.clr_by_latch = wr_acc && (rsel == REG_LAT_HI);

        case (rsel)
            REG_CNT_LO: rdata = cnt[BYTE_W-1:0];
            REG_CNT_HI: rdata = cnt[CNT_W-1:BYTE_W];
            REG_LAT_LO: rdata = lat_lo;
            default:    rdata = lat_hi;
        endcase
    end

endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  bus_cmd_t              cmd,
    input  logic [BYTE_W-1:0]     wdata,
    input  logic                  aux_wr,
    input  logic [1:0]            aux_mode,
    input  logic                  flag_clr,
    output logic [2*BYTE_W-1:0]   cnt,
    output logic [BYTE_W-1:0]     lat_lo,
    output logic [BYTE_W-1:0]     lat_hi,
    output logic                  flag,
    output logic                  lvl,
    output logic                  out_en
);
    localparam int               CNT_W    = 2 * BYTE_W;
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;

    tmr_ctl_t          ctl_d, ctl_q;
    logic [CNT_W-1:0]  cnt_d, cnt_q;
    logic [BYTE_W-1:0] lat_lo_d, lat_lo_q;
    logic [BYTE_W-1:0] lat_hi_d, lat_hi_q;

    logic at_zero;
    logic timeout;
    logic flag_set;
    logic flag_kill;

    always_comb begin
        at_zero   = (cnt_q == CNT_ZERO);
        timeout   = at_zero && !cmd.start;
        flag_set  = timeout && (ctl_q.free_run || ctl_q.armed);
        flag_kill = cmd.start || cmd.rd_cnt_lo || cmd.clr_by_latch || flag_clr;

        ctl_d    = ctl_q;
        lat_lo_d = lat_lo_q;
        lat_hi_d = lat_hi_q;
        cnt_d    = cnt_q - CNT_ONE;

        if (cmd.wr_lat_lo) lat_lo_d = wdata;
        if (cmd.wr_lat_hi) lat_hi_d = wdata;

        if (cmd.start) begin
            cnt_d = {wdata, lat_lo_q};
        end else if (timeout && ctl_q.free_run) begin
            cnt_d = {lat_hi_q, lat_lo_q};
        end

        if (flag_set) begin
            ctl_d.flag = 1'b1;
        end else if (flag_kill) begin
            ctl_d.flag = 1'b0;
        end

        if (cmd.start) begin
            ctl_d.armed = 1'b1;
            ctl_d.lvl   = 1'b0;
        end else if (timeout) begin
            if (ctl_q.free_run) begin
                ctl_d.lvl = !ctl_q.lvl;
            end else begin
                ctl_d.armed = 1'b0;
                ctl_d.lvl   = 1'b1;
            end
        end

        if (aux_wr) begin
            ctl_d.out_en   = aux_mode[1];
            ctl_d.free_run = aux_mode[0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= CTL_RESET;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_ff @(posedge clk) begin
        cnt_q    <= cnt_d;
        lat_lo_q <= lat_lo_d;
        lat_hi_q <= lat_hi_d;
    end

    assign cnt    = cnt_q;
    assign lat_lo = lat_lo_q;
    assign lat_hi = lat_hi_q;
    assign flag   = ctl_q.flag;
    assign lvl    = ctl_q.lvl;
    assign out_en = ctl_q.out_en;

    a_r2_start_load: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.start |=> (cnt_q == {$past(wdata), $past(lat_lo_q)}) && !ctl_q.flag);

    a_r3_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd.start && (cnt_q != CNT_ZERO)) |=> (cnt_q == $past(cnt_q) - CNT_ONE));

    a_r8_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd.start && (cnt_q == CNT_ZERO) && ctl_q.free_run && !aux_wr)
        |=> (cnt_q == {$past(lat_hi_q), $past(lat_lo_q)}) && ctl_q.flag
            && (ctl_q.lvl != $past(ctl_q.lvl)));

    a_r7_single_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd.start && !ctl_q.armed && !ctl_q.free_run && !ctl_q.flag) |=> !ctl_q.flag);

    a_r9_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.start |=> !ctl_q.lvl);

endmodule

// File: rtl/tmr_pin_mux.sv
module tmr_pin_mux (
    input  logic timer_owns,
    input  logic timer_lvl,
    input  logic port_bit,
    input  logic port_dir,
    output logic pin,
    output logic pin_oe
);
    always_comb begin
        if (timer_owns) begin
            pin    = timer_lvl;
            pin_oe = 1'b1;
        end else begin
            pin    = port_bit;
            pin_oe = port_dir;
        end
    end
endmodule

// File: rtl/latch_interval_timer.sv
module latch_interval_timer
    import tmr_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [1:0]        bus_addr_i,
    input  logic [BYTE_W-1:0] bus_wdata_i,
    output logic [BYTE_W-1:0] bus_rdata_o,
    input  logic              aux_wr_i,
    input  logic [1:0]        aux_mode_i,
    input  logic              irq_en_i,
    input  logic              flag_clr_i,
    input  logic              port_bit_i,
    input  logic              port_dir_i,
    output logic              flag_o,
    output logic              irq_o,
    output logic              pin_o,
    output logic              pin_oe_o
);
    localparam int CNT_W = 2 * BYTE_W;

    bus_cmd_t          cmd;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] lat_lo;
    logic [BYTE_W-1:0] lat_hi;
    logic              flag;
    logic              lvl;
    logic              out_en;

    tmr_regif #(.BYTE_W(BYTE_W)) u_regif (
        .sel    (bus_sel_i),
        .wr     (bus_wr_i),
        .addr   (bus_addr_i),
        .cnt    (cnt),
        .lat_lo (lat_lo),
        .lat_hi (lat_hi),
        .cmd    (cmd),
        .rdata  (bus_rdata_o)
    );

    tmr_core #(.BYTE_W(BYTE_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd),
        .wdata    (bus_wdata_i),
        .aux_wr   (aux_wr_i),
        .aux_mode (aux_mode_i),
        .flag_clr (flag_clr_i),
        .cnt      (cnt),
        .lat_lo   (lat_lo),
        .lat_hi   (lat_hi),
        .flag     (flag),
        .lvl      (lvl),
        .out_en   (out_en)
    );

    tmr_pin_mux u_pin (
        .timer_owns (out_en),
        .timer_lvl  (lvl),
        .port_bit   (port_bit_i),
        .port_dir   (port_dir_i),
        .pin        (pin_o),
        .pin_oe     (pin_oe_o)
    );

    assign flag_o = flag;
    assign irq_o  = flag && irq_en_i;

endmodule

// File: tb/test_latch_interval_timer.sv
`timescale 1ns/1ps
module test_latch_interval_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel = 1'b0, wr = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       aux_wr = 1'b0;
    logic [1:0] aux_mode = 2'd0;
    logic       irq_en = 1'b1, flag_clr = 1'b0;
    logic       port_bit = 1'b1, port_dir = 1'b0;
    logic       flag_o, irq_o, pin_o, pin_oe_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    latch_interval_timer #(.BYTE_W(8)) i_latch_interval_timer (
        .clk(clk), .rst_n(rst_n),
        .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .aux_wr_i(aux_wr), .aux_mode_i(aux_mode),
        .irq_en_i(irq_en), .flag_clr_i(flag_clr),
        .port_bit_i(port_bit), .port_dir_i(port_dir),
        .flag_o(flag_o), .irq_o(irq_o), .pin_o(pin_o), .pin_oe_o(pin_oe_o)
    );

    // behavioural reference
    int m_cnt = 0, m_llo = 0, m_lhi = 0;
    bit m_flag = 0, m_armed = 0, m_lvl = 1, m_oen = 0, m_free = 0;
    bit m_on = 0, m_loaded = 0;
    bit st, to, setf, clrf;

    always @(posedge clk) begin
        st   = sel && wr && addr == 2'd1;
        to   = !st && m_cnt == 0;
        setf = to && (m_free || m_armed);
        clrf = st || (sel && !wr && addr == 2'd0) || (sel && wr && addr == 2'd3) || flag_clr;
        if (st) m_cnt = {wdata, m_llo[7:0]};
        else if (to && m_free) m_cnt = (m_lhi << 8) | m_llo;
        else m_cnt = (m_cnt + 65535) % 65536;
        if (setf) m_flag = 1; else if (clrf) m_flag = 0;
        if (st) begin m_armed = 1; m_lvl = 0; end
        else if (to) begin
            if (m_free) m_lvl = !m_lvl;
            else begin m_armed = 0; m_lvl = 1; end
        end
        if (sel && wr && (addr == 2'd0 || addr == 2'd2)) m_llo = wdata;
        if (sel && wr && (addr == 2'd1 || addr == 2'd3)) m_lhi = wdata;
        if (aux_wr) begin m_oen = aux_mode[1]; m_free = aux_mode[0]; end
        if (st) m_loaded = 1;
        if (!rst_n) begin
            m_flag = 0; m_armed = 0; m_lvl = 1; m_oen = 0; m_free = 0;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int m_byte(input logic [1:0] a);
        case (a)
            2'd0: return m_cnt & 255;
            2'd1: return (m_cnt >> 8) & 255;
            2'd2: return m_llo;
            default: return m_lhi;
        endcase
    endfunction

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        #2;
        if (m_on) begin
            chk("R6 R8 flag_o", flag_o, m_flag);
            chk("R11 irq_o", irq_o, m_flag && irq_en);
            chk("R10 pin_o", pin_o, m_oen ? m_lvl : port_bit);
            chk("R10 pin_oe_o", pin_oe_o, m_oen ? 1 : port_dir);
            if (m_loaded) chk("R5 rdata", rdata, m_byte(addr));
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        sel = 1; wr = 1; addr = a; wdata = d;
        cyc(1);
        sel = 0; wr = 0;
    endtask

    task automatic peek(input logic [1:0] a, output int v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic set_mode(input logic [1:0] m);
        aux_wr = 1; aux_mode = m;
        cyc(1);
        aux_wr = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int v;
        @(negedge clk);
        cyc(3);
        m_on = 1;
        #1;
        chk("R1 flag after reset", flag_o, 0);
        chk("R1 irq after reset", irq_o, 0);
        chk("R1 pin follows port", pin_o, 1);
        chk("R1 oe follows port", pin_oe_o, 0);
        rst_n = 1;
        cyc(1);

        // one-shot with pin output
        set_mode(2'b10);
        wr_reg(2'd2, 8'h05);
        wr_reg(2'd1, 8'h00);
        peek(2'd0, v); chk("R2 low count loaded", v, 5);
        peek(2'd1, v); chk("R2 high count loaded", v, 0);
        chk("R2 flag clear after start", flag_o, 0);
        chk("R9 level low after start", pin_o, 0);
        cyc(1);
        peek(2'd0, v); chk("R3 decrement", v, 4);
        cyc(4);
        peek(2'd0, v); chk("R3 reached zero", v, 0);
        chk("R6 no flag before wrap", flag_o, 0);
        cyc(1);
        chk("R6 flag at timeout", flag_o, 1);
        chk("R9 level high at timeout", pin_o, 1);
        peek(2'd1, v); chk("R6 counter wraps to ones", v, 8'hFF);
        chk("R11 irq with enable", irq_o, 1);
        irq_en = 0; #1;
        chk("R11 irq masked", irq_o, 0);
        irq_en = 1;
        flag_clr = 1;
        cyc(1);
        flag_clr = 0;
        chk("R12 direct clear", flag_o, 0);
        cyc(65536);
        chk("R7 no second flag", flag_o, 0);
        peek(2'd0, v); chk("R6 counter keeps running", v, 8'hFE);

        // latch-only writes during a countdown
        wr_reg(2'd2, 8'h40);
        wr_reg(2'd1, 8'h01);
        cyc(3);
        wr_reg(2'd2, 8'h11);
        wr_reg(2'd3, 8'h22);
        peek(2'd0, v); chk("R4 count undisturbed lo", v, 8'h3B);
        peek(2'd1, v); chk("R4 count undisturbed hi", v, 8'h01);
        peek(2'd2, v); chk("R5 low latch read", v, 8'h11);
        peek(2'd3, v); chk("R5 high latch read", v, 8'h22);

        // free-running
        set_mode(2'b11);
        wr_reg(2'd2, 8'h03);
        wr_reg(2'd3, 8'h00);
        wr_reg(2'd1, 8'h00);
        cyc(4);
        chk("R8 flag on reload", flag_o, 1);
        chk("R8 level toggled high", pin_o, 1);
        peek(2'd0, v); chk("R8 reloaded", v, 3);
        cyc(4);
        chk("R8 level toggled low", pin_o, 0);
        sel = 1; wr = 0; addr = 2'd0;
        #1; chk("R5 read low count", rdata, 3);
        cyc(1);
        sel = 0;
        chk("R5 read clears flag", flag_o, 0);
        cyc(2);
        flag_clr = 1;
        cyc(1);
        flag_clr = 0;
        chk("R12 set wins over clear", flag_o, 1);
        wr_reg(2'd3, 8'h00);
        chk("R4 high latch write clears flag", flag_o, 0);

        // pin ownership
        set_mode(2'b00);
        port_dir = 1; port_bit = 0; #1;
        chk("R10 port drives pin", pin_o, 0);
        chk("R10 port direction", pin_oe_o, 1);
        port_dir = 0; port_bit = 1; #1;
        chk("R10 port input", pin_oe_o, 0);
        set_mode(2'b10);
        chk("R13 mode strobe loads", pin_oe_o, 1);
        port_bit = 0; #1;
        chk("R10 port bit ignored", pin_o, m_lvl);
        port_bit = 1; #1;
        chk("R10 port bit ignored again", pin_o, m_lvl);

        // reset mid-operation
        set_mode(2'b11);
        rst_n = 0;
        cyc(2);
        chk("R1 flag cleared", flag_o, 0);
        chk("R1 mode cleared", pin_oe_o, 0);
        peek(2'd2, v); chk("R1 low latch kept", v, 3);
        peek(2'd3, v); chk("R1 high latch kept", v, 0);
        rst_n = 1;
        cyc(2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule